// File: doc/BRIEF.md
# Windowed Subsampling Readout Address Generator

This block produces the sequence of row and column addresses that reads a pixel array of 1280 columns by 1024 rows. Software programs up to four rectangular regions. Each region has an inclusive start and stop position on both axes. After a frame start pulse, the generator visits the active regions from the lowest index to the highest. Inside a region it walks row by row, and the column address rises within each row. A downstream reader takes each address with a ready-style `advance` handshake.

An optional subsampling mode thins both axes with a fixed keep/skip rhythm, so resolution drops while the field of view stays the same. The monochrome rhythm keeps every second coordinate. The color rhythm keeps two coordinates and skips two, so 2x2 filter groups stay whole. The rhythm is measured from the start coordinate of the current region on each axis. Flags mark the last address of each row and the last address of the frame. After the last address the generator stays idle until the next frame start.

Top module: `roiScanGen`

## Requirements
- R1: Stop coordinates above the array limits are clamped to row 1023 and column 1279. No valid address is ever outside the array.
- R2: A region is read row by row from top to bottom, with the column rising inside each row. Regions are visited in ascending index order, and `winIdx` gives the index of the region being read.
- R3: `winCountSel` sets how many regions are active: 0 gives one, 1 gives two, 2 gives three and 3 gives four (indices 0 to `winCountSel`). Regions with a higher index produce no addresses.
- R4: Stop coordinates are inclusive. A region whose start is greater than its clamped stop on either axis produces no addresses and is skipped.
- R5: With `subEn` low, every coordinate from start to stop is produced on both axes.
- R6: With `subEn` high and `subColor` low, only the coordinates whose offset from the region start is even are produced on both axes.
- R7: With `subEn` high and `subColor` high, only the coordinates whose offset from the region start, taken modulo 4, is 0 or 1 are produced on both axes.
- R8: The keep/skip rhythm starts again at the start coordinate of every region, and the column rhythm starts again at every new row.
- R9: While `addrValid` is high and `advance` is low, the address and flags hold. An address is consumed on a clock edge where both are high. The first address is valid two clock edges after the edge that samples `frameStart`.
- R10: `endOfRow` is high with the last address of each row of a region. `endOfFrame` is high together with the final address of the last non-empty active region. After that address is consumed, `addrValid` stays low until the next `frameStart`.
- R11: A `frameStart` pulse that arrives while a frame is being read is ignored.
- R12: After reset, and while reset is asserted, `addrValid`, `endOfRow` and `endOfFrame` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| frameStart | input | 1 | Pulse that starts the reading of a frame |
| advance | input | 1 | The downstream reader takes the current address |
| winCountSel | input | 2 | Number of active regions minus one |
| subEn | input | 1 | Subsampling enable |
| subColor | input | 1 | 1: keep two, skip two; 0: keep one, skip one |
| rowStartCfg | input | 40 | Row start of each region, 10 bits per region, region 0 in the low bits |
| rowStopCfg | input | 40 | Inclusive row stop of each region, same packing |
| colStartCfg | input | 44 | Column start of each region, 11 bits per region, region 0 in the low bits |
| colStopCfg | input | 44 | Inclusive column stop of each region, same packing |
| rowAddr | output | 10 | Current row address |
| colAddr | output | 11 | Current column address |
| winIdx | output | 2 | Index of the region being read |
| addrValid | output | 1 | Current address is valid |
| endOfRow | output | 1 | Current address is the last of its row |
| endOfFrame | output | 1 | Current address is the last of the frame |

## Verification
The hardest case to reach from the ports is a frame in which empty regions lie before and after the non-empty ones. The generator must skip the leading empty regions without producing anything. It must also raise `endOfFrame` on an earlier region, because the regions after it add nothing. The stimulus table therefore includes frames where an empty region comes first, where an empty region comes last, where a start coordinate lies past the array edge, and where every region is empty. The bench models each expected address stream and compares it with the output one address at a time. It drives `advance` from a pseudo-random sequence on half of the frames, so that stalls land on row ends, region changes and the final address.

// File: rtl/roiScanPkg.sv
package roiScanPkg;

  // strobes from the sequencing control to the address datapath
  typedef struct packed {
    logic clearWin;  // restart at region 0
    logic nextWin;   // move to the next region index
    logic loadWin;   // load both axes with the current region start
    logic stepRow;   // next kept row, column back to start
    logic stepCol;   // next kept column
  } scanStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEEK = 2'd1,
    ST_SCAN = 2'd2
  } scanState_t;

endpackage

// File: rtl/roiAxisStep.sv
module roiAxisStep #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         load,
  input  logic         step,
  input  logic         subEn,
  input  logic         subColor,
  input  logic [W-1:0] startVal,
  input  logic [W-1:0] stopVal,
  output logic [W-1:0] cur,
  output logic         last
);

  logic [W-1:0] curQ;
  logic         phaseQ;   // color rhythm: 0 = first of a kept pair
  logic [W+1:0] stepAmt;
  logic [W+1:0] nextVal;

  always_comb begin
    if (!subEn)         stepAmt = (W+2)'(1);
    else if (!subColor) stepAmt = (W+2)'(2);
    else if (phaseQ)    stepAmt = (W+2)'(3);
    else                stepAmt = (W+2)'(1);
    nextVal = {2'b00, curQ} + stepAmt;
    last    = nextVal > {2'b00, stopVal};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curQ   <= '0;
      phaseQ <= 1'b0;
    end else if (load) begin
      curQ   <= startVal;
      phaseQ <= 1'b0;
    end else if (step) begin
      curQ   <= nextVal[W-1:0];
      phaseQ <= subEn & subColor & ~phaseQ;
    end
  end

  assign cur = curQ;

  AST_STEP_FORWARD: assert property (@(posedge clk) disable iff (!rstN)
    (step && !load) |=> (curQ > $past(curQ)));  // R2

endmodule

// File: rtl/roiScanPath.sv
module roiScanPath import roiScanPkg::*; #(
  parameter int ROWS    = 1024,
  parameter int COLS    = 1280,
  parameter int NUM_WIN = 4
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  scanStrobe_t                         strobe,
  input  logic [$clog2(NUM_WIN)-1:0]          winCountSel,
  input  logic                                subEn,
  input  logic                                subColor,
  input  logic [NUM_WIN*$clog2(ROWS)-1:0]     rowStartCfg,
  input  logic [NUM_WIN*$clog2(ROWS)-1:0]     rowStopCfg,
  input  logic [NUM_WIN*$clog2(COLS)-1:0]     colStartCfg,
  input  logic [NUM_WIN*$clog2(COLS)-1:0]     colStopCfg,
  output logic [$clog2(ROWS)-1:0]             rowAddr,
  output logic [$clog2(COLS)-1:0]             colAddr,
  output logic [$clog2(NUM_WIN)-1:0]          winIdx,
  output logic                                colLast,
  output logic                                rowLast,
  output logic                                curEmpty,
  output logic                                laterActive
);

  localparam int RW = $clog2(ROWS);
  localparam int CW = $clog2(COLS);
  localparam int IW = $clog2(NUM_WIN);
  localparam logic [RW-1:0] ROW_MAX = RW'(ROWS - 1);
  localparam logic [CW-1:0] COL_MAX = CW'(COLS - 1);

  logic [RW-1:0] rStartArr [NUM_WIN];
  logic [RW-1:0] rStopArr  [NUM_WIN];
  logic [CW-1:0] cStartArr [NUM_WIN];
  logic [CW-1:0] cStopArr  [NUM_WIN];
  logic [NUM_WIN-1:0] nonEmpty;
  logic [NUM_WIN-1:0] laterMask;
  logic [IW-1:0] winIdxQ;

  // per-region clamp and emptiness
  for (genvar i = 0; i < NUM_WIN; i++) begin : gWin
    logic [RW-1:0] rawRowStop;
    logic [CW-1:0] rawColStop;
    assign rStartArr[i] = rowStartCfg[i*RW +: RW];
    assign cStartArr[i] = colStartCfg[i*CW +: CW];
    assign rawRowStop   = rowStopCfg[i*RW +: RW];
    assign rawColStop   = colStopCfg[i*CW +: CW];
    assign rStopArr[i]  = (rawRowStop > ROW_MAX) ? ROW_MAX : rawRowStop;
    assign cStopArr[i]  = (rawColStop > COL_MAX) ? COL_MAX : rawColStop;
    assign nonEmpty[i]  = (IW'(i) <= winCountSel) &&
                          (rStartArr[i] <= rStopArr[i]) &&
                          (cStartArr[i] <= cStopArr[i]);
    assign laterMask[i] = IW'(i) > winIdxQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                winIdxQ <= '0;
    else if (strobe.clearWin) winIdxQ <= '0;
    else if (strobe.nextWin)  winIdxQ <= winIdxQ + IW'(1);
  end

  assign curEmpty    = ~nonEmpty[winIdxQ];
  assign laterActive = |(nonEmpty & laterMask);
  assign winIdx      = winIdxQ;

  roiAxisStep #(.W(RW)) uRowAxis (
    .clk      (clk),
    .rstN     (rstN),
    .load     (strobe.loadWin),
    .step     (strobe.stepRow),
    .subEn    (subEn),
    .subColor (subColor),
    .startVal (rStartArr[winIdxQ]),
    .stopVal  (rStopArr[winIdxQ]),
    .cur      (rowAddr),
    .last     (rowLast)
  );

  roiAxisStep #(.W(CW)) uColAxis (
    .clk      (clk),
    .rstN     (rstN),
    .load     (strobe.loadWin | strobe.stepRow),
    .step     (strobe.stepCol),
    .subEn    (subEn),
    .subColor (subColor),
    .startVal (cStartArr[winIdxQ]),
    .stopVal  (cStopArr[winIdxQ]),
    .cur      (colAddr),
    .last     (colLast)
  );

  AST_NEXT_WIN_FORWARD: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.nextWin && !strobe.clearWin) |=> (winIdxQ > $past(winIdxQ)));  // R2

  AST_LOAD_NONEMPTY: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadWin |-> nonEmpty[winIdxQ]);  // R4

endmodule

// File: rtl/roiScanCtrl.sv
module roiScanCtrl import roiScanPkg::*; (
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameStart,
  input  logic        advance,
  input  logic        colLast,
  input  logic        rowLast,
  input  logic        curEmpty,
  input  logic        laterActive,
  output scanStrobe_t strobe,
  output logic        addrValid,
  output logic        endOfRow,
  output logic        endOfFrame
);

  scanState_t stateQ, stateD;

  always_comb begin
    strobe = '0;
    stateD = stateQ;
    case (stateQ)
      ST_IDLE: begin
        if (frameStart) begin
          strobe.clearWin = 1'b1;
          stateD          = ST_SEEK;
        end
      end
      ST_SEEK: begin
        if (!curEmpty) begin
          strobe.loadWin = 1'b1;
          stateD         = ST_SCAN;
        end else if (laterActive) begin
          strobe.nextWin = 1'b1;
        end else begin
          stateD = ST_IDLE;
        end
      end
      ST_SCAN: begin
        if (advance) begin
          if (!colLast) begin
            strobe.stepCol = 1'b1;
          end else if (!rowLast) begin
            strobe.stepRow = 1'b1;
          end else if (laterActive) begin
            strobe.nextWin = 1'b1;
            stateD         = ST_SEEK;
          end else begin
            stateD = ST_IDLE;
          end
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign addrValid  = (stateQ == ST_SCAN);
  assign endOfRow   = addrValid & colLast;
  assign endOfFrame = addrValid & colLast & rowLast & ~laterActive;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe));  // R2

  AST_IDLE_AFTER_EOF: assert property (@(posedge clk) disable iff (!rstN)
    (endOfFrame && advance) |=> !addrValid);  // R10

  AST_FS_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && frameStart && !advance) |=> addrValid);  // R11

endmodule

// File: rtl/roiScanGen.sv
module roiScanGen import roiScanPkg::*; #(
  parameter int ROWS    = 1024,
  parameter int COLS    = 1280,
  parameter int NUM_WIN = 4
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            frameStart,
  input  logic                            advance,
  input  logic [$clog2(NUM_WIN)-1:0]      winCountSel,
  input  logic                            subEn,
  input  logic                            subColor,
  input  logic [NUM_WIN*$clog2(ROWS)-1:0] rowStartCfg,
  input  logic [NUM_WIN*$clog2(ROWS)-1:0] rowStopCfg,
  input  logic [NUM_WIN*$clog2(COLS)-1:0] colStartCfg,
  input  logic [NUM_WIN*$clog2(COLS)-1:0] colStopCfg,
  output logic [$clog2(ROWS)-1:0]         rowAddr,
  output logic [$clog2(COLS)-1:0]         colAddr,
  output logic [$clog2(NUM_WIN)-1:0]      winIdx,
  output logic                            addrValid,
  output logic                            endOfRow,
  output logic                            endOfFrame
);

  scanStrobe_t strobe;
  logic colLast, rowLast, curEmpty, laterActive;

  roiScanCtrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .frameStart  (frameStart),
    .advance     (advance),
    .colLast     (colLast),
    .rowLast     (rowLast),
    .curEmpty    (curEmpty),
    .laterActive (laterActive),
    .strobe      (strobe),
    .addrValid   (addrValid),
    .endOfRow    (endOfRow),
    .endOfFrame  (endOfFrame)
  );

  roiScanPath #(.ROWS(ROWS), .COLS(COLS), .NUM_WIN(NUM_WIN)) uPath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .winCountSel (winCountSel),
    .subEn       (subEn),
    .subColor    (subColor),
    .rowStartCfg (rowStartCfg),
    .rowStopCfg  (rowStopCfg),
    .colStartCfg (colStartCfg),
    .colStopCfg  (colStopCfg),
    .rowAddr     (rowAddr),
    .colAddr     (colAddr),
    .winIdx      (winIdx),
    .colLast     (colLast),
    .rowLast     (rowLast),
    .curEmpty    (curEmpty),
    .laterActive (laterActive)
  );

  AST_ROW_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    addrValid |-> (int'(rowAddr) < ROWS));  // R1
  AST_COL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    addrValid |-> (int'(colAddr) < COLS));  // R1
  AST_WIN_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    addrValid |-> (winIdx <= winCountSel));  // R3
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && !advance) |=> (addrValid && $stable(rowAddr) &&
                                 $stable(colAddr) && $stable(winIdx)));  // R9
  AST_EOF_ON_ROW_END: assert property (@(posedge clk) disable iff (!rstN)
    endOfFrame |-> endOfRow);  // R10

endmodule

// File: tb/sim_roiScanGen.sv
module sim_roiScanGen;

  typedef struct packed {
    logic [1:0]  wc;
    logic        se;
    logic        sc;
    logic [39:0] rs;
    logic [39:0] re;
    logic [43:0] cs;
    logic [43:0] ce;
  } vec_t;

  // region order inside each field: {region3, region2, region1, region0}
  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{wc:2'd0, se:1'b0, sc:1'b0,
      rs:{10'd0, 10'd0, 10'd0, 10'd10},   re:{10'd0, 10'd0, 10'd0, 10'd12},
      cs:{11'd0, 11'd0, 11'd0, 11'd20},   ce:{11'd0, 11'd0, 11'd0, 11'd25}},
    '{wc:2'd3, se:1'b1, sc:1'b0,
      rs:{10'd1, 10'd100, 10'd7, 10'd0},  re:{10'd1, 10'd102, 10'd10, 10'd4},
      cs:{11'd1, 11'd1000, 11'd3, 11'd0}, ce:{11'd1, 11'd1003, 11'd8, 11'd6}},
    '{wc:2'd1, se:1'b1, sc:1'b1,
      rs:{10'd0, 10'd0, 10'd3, 10'd0},    re:{10'd0, 10'd0, 10'd7, 10'd5},
      cs:{11'd0, 11'd0, 11'd5, 11'd10},   ce:{11'd0, 11'd0, 11'd9, 11'd17}},
    '{wc:2'd2, se:1'b1, sc:1'b1,
      rs:{10'd0, 10'd10, 10'd5, 10'd2},   re:{10'd0, 10'd5, 10'd9, 10'd3},
      cs:{11'd0, 11'd0, 11'd1, 11'd2},    ce:{11'd0, 11'd3, 11'd4, 11'd2}},
    '{wc:2'd3, se:1'b1, sc:1'b0,
      rs:{10'd0, 10'd0, 10'd1020, 10'd0}, re:{10'd0, 10'd5, 10'd1023, 10'd3},
      cs:{11'd0, 11'd1500, 11'd1275, 11'd30}, ce:{11'd2, 11'd1600, 11'd2000, 11'd20}},
    '{wc:2'd0, se:1'b0, sc:1'b0,
      rs:{10'd1, 10'd2, 10'd3, 10'd5},    re:{10'd9, 10'd9, 10'd9, 10'd5},
      cs:{11'd1, 11'd2, 11'd3, 11'd5},    ce:{11'd9, 11'd9, 11'd9, 11'd5}},
    '{wc:2'd0, se:1'b0, sc:1'b0,
      rs:{10'd0, 10'd0, 10'd0, 10'd9},    re:{10'd0, 10'd0, 10'd0, 10'd4},
      cs:{11'd0, 11'd0, 11'd0, 11'd0},    ce:{11'd0, 11'd0, 11'd0, 11'd3}},
    '{wc:2'd1, se:1'b0, sc:1'b0,
      rs:{10'd0, 10'd0, 10'd0, 10'd1},    re:{10'd0, 10'd0, 10'd1, 10'd3},
      cs:{11'd0, 11'd0, 11'd1278, 11'd8}, ce:{11'd0, 11'd0, 11'd1279, 11'd2}}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameStart = 1'b0;
  logic advance = 1'b0;
  logic [1:0] winCountSel = '0;
  logic subEn = 1'b0;
  logic subColor = 1'b0;
  logic [39:0] rowStartCfg = '0, rowStopCfg = '0;
  logic [43:0] colStartCfg = '0, colStopCfg = '0;
  logic [9:0]  rowAddr;
  logic [10:0] colAddr;
  logic [1:0]  winIdx;
  logic addrValid, endOfRow, endOfFrame;

  always #2 clk = ~clk;

  roiScanGen u0 (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .advance(advance),
    .winCountSel(winCountSel), .subEn(subEn), .subColor(subColor),
    .rowStartCfg(rowStartCfg), .rowStopCfg(rowStopCfg),
    .colStartCfg(colStartCfg), .colStopCfg(colStopCfg),
    .rowAddr(rowAddr), .colAddr(colAddr), .winIdx(winIdx),
    .addrValid(addrValid), .endOfRow(endOfRow), .endOfFrame(endOfFrame)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  int cycles = 0;
  logic [15:0] lfsr = 16'hACE1;

  int expRow [4096];
  int expCol [4096];
  int expWin [4096];
  bit expEor [4096];
  bit expEof [4096];
  int expN;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit keep(input int c, input int s, input bit se, input bit sc);
    int per;
    if (!se) return 1'b1;
    per = sc ? 4 : 2;
    return ((c - s) % per) < (per / 2);
  endfunction

  // independent model: enumerate and filter every coordinate
  task automatic buildExp(input vec_t v);
    expN = 0;
    for (int w = 0; w <= int'(v.wc); w++) begin
      int rs, re, cs, ce;
      rs = int'(v.rs[w*10 +: 10]);
      re = int'(v.re[w*10 +: 10]);
      cs = int'(v.cs[w*11 +: 11]);
      ce = int'(v.ce[w*11 +: 11]);
      if (re > 1023) re = 1023;
      if (ce > 1279) ce = 1279;
      for (int r = rs; r <= re; r++) begin
        if (keep(r, rs, v.se, v.sc)) begin
          for (int c = cs; c <= ce; c++) begin
            if (keep(c, cs, v.se, v.sc)) begin
              expRow[expN] = r; expCol[expN] = c; expWin[expN] = w;
              expEor[expN] = 1'b0; expEof[expN] = 1'b0;
              expN++;
            end
          end
          if (expN > 0) expEor[expN-1] = 1'b1;
        end
      end
    end
    if (expN > 0) expEof[expN-1] = 1'b1;
  endtask

  function automatic string reqOf(input int v);
    case (v)
      0: return "R5";
      1: return "R6";
      2: return "R7";
      3: return "R8";
      4: return "R1";
      5: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic applyCfg(input vec_t v);
    winCountSel = v.wc; subEn = v.se; subColor = v.sc;
    rowStartCfg = v.rs; rowStopCfg = v.re;
    colStartCfg = v.cs; colStopCfg = v.ce;
  endtask

  task automatic runVec(input int v);
    int got;
    bit bad;
    bit fsDone;
    string rq;
    rq = reqOf(v);
    applyCfg(VECS[v]);
    buildExp(VECS[v]);
    @(negedge clk) frameStart = 1'b1;
    @(negedge clk) frameStart = 1'b0;
    got = 0; bad = 1'b0; fsDone = 1'b0;
    for (int k = 0; k < expN * 4 + 40; k++) begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      advance = (v % 2 == 0) ? 1'b1 : lfsr[0];
      frameStart = 1'b0;
      if (v == 1 && got == 3 && !fsDone) begin
        frameStart = 1'b1;  // R11: pulse during a frame
        fsDone = 1'b1;
      end
      if (addrValid) begin
        if (got >= expN) begin
          if (!bad) check(1'b0, "R10", "extra address", got, expN);
          bad = 1'b1;
        end else begin
          // R2 order, plus the rhythm requirement of this vector
          check(int'(rowAddr) == expRow[got], rq, "rowAddr", int'(rowAddr), expRow[got]);
          check(int'(colAddr) == expCol[got], rq, "colAddr", int'(colAddr), expCol[got]);
          check(int'(winIdx) == expWin[got], "R2", "winIdx", int'(winIdx), expWin[got]);
          check(endOfRow == expEor[got], "R10", "endOfRow", int'(endOfRow), int'(expEor[got]));
          check(endOfFrame == expEof[got], "R10", "endOfFrame", int'(endOfFrame), int'(expEof[got]));
          if (advance) got++;
        end
      end
    end
    frameStart = 1'b0;
    check(got == expN, (v == 1) ? "R11" : "R4", "address count", got, expN);
    check(!addrValid, "R10", "idle after frame", int'(addrValid), 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000 && !finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R12: reset state
    repeat (3) @(negedge clk);
    check(!addrValid && !endOfRow && !endOfFrame, "R12", "flags in reset",
          int'({addrValid, endOfRow, endOfFrame}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!addrValid, "R12", "valid after reset", int'(addrValid), 0);

    // R9: latency and stall hold
    applyCfg(VECS[0]);
    advance = 1'b0;
    frameStart = 1'b1;
    @(negedge clk) frameStart = 1'b0;
    check(!addrValid, "R9", "valid one edge after start", int'(addrValid), 0);
    @(negedge clk);
    check(addrValid, "R9", "valid two edges after start", int'(addrValid), 1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(addrValid && rowAddr == 10'd10 && colAddr == 11'd20, "R9", "hold while stalled",
            int'(colAddr), 20);
    end
    // R12: reset during a frame
    advance = 1'b1;
    repeat (2) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check(!addrValid, "R12", "valid cleared by reset", int'(addrValid), 0);
    rstN = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) runVec(v);

    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule